// File: doc/BRIEF.md
# Dual-Channel Synthesizer Serial Configuration Loader

This block takes a three-wire serial configuration stream (bit clock, bit data, load strobe) and turns it into the static settings of a two-channel frequency synthesizer. A high channel and a low channel each own two holding registers: a reference word and a counter word. The reference word carries the reference divider, phase sense, pump current, output high-impedance and monitor-select bits. The counter word carries the swallow count, main divider, prescaler ratio and power-down bits. All three pins are asynchronous to the system clock. They pass through a synchronizer chain, and the bit clock and load strobe are then edge-detected.

A host shifts a 22-bit word with the most significant bit first. It then raises the load strobe. The two bits shifted in last act as an address and pick which of the four holding registers takes the word. The low channel's swallow field is narrower than the high channel's, so the surplus bits of that field are dropped when the word is stored. Words can be loaded at any time, including while a channel is powered down.

Top module: `dual_pll_cfg_loader`

## Requirements
- R1: After reset every holding register is zero, except that both power-down outputs are 1.
- R2: Each synchronized rising edge of the bit clock shifts one data bit into a 22-bit shift word at bit 0, moving older bits toward bit 21. Only the last 22 bits shifted are kept, so the first bit sent ends up in bit 21.
- R3: A synchronized rising edge of the load strobe copies the shift word into one register chosen by its bits [1:0]: 00 low-channel reference, 01 low-channel counter, 10 high-channel reference, 11 high-channel counter.
- R4: In a reference word, bits [16:2] are the reference divider (bit 2 is its LSB), bit 17 is phase sense, bit 18 is pump-current high, bit 19 is output high-impedance, bit 20 is monitor lock select and bit 21 is monitor divider select.
- R5: In a counter word, bits [19:9] are the main divider (bit 9 is its LSB), bit 20 is the wide prescaler select and bit 21 is power-down. The high-channel swallow count is bits [8:2].
- R6: The low-channel swallow count is bits [5:2] of its counter word. Bits [8:6] of that word have no effect on any output.
- R7: A load changes only the register it selects; the other three hold their values.
- R8: Falling edges of the bit clock or load strobe, and data changes while the bit clock is steady, change nothing. The shift word is kept after a load, so a second strobe loads the same word again, and the bit clock may stay high across a load.
- R9: Loads take effect whatever the power-down state of either channel.
- R10: A load-strobe rise first seen at a clock edge updates the outputs SYNC_STAGES+1 clock edges later. When bit-clock and strobe rises reach the logic in the same cycle, the word loaded is the one before that cycle's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_bit_dat_i | input | 1 | Serial data bit (asynchronous) |
| ser_strobe_i | input | 1 | Load strobe (asynchronous) |
| hi_ref_div_o | output | 15 | High-channel reference divider |
| hi_phase_pos_o | output | 1 | High-channel phase sense |
| hi_pump_hi_o | output | 1 | High-channel pump current high |
| hi_out_hiz_o | output | 1 | High-channel output high-impedance |
| hi_mon_lock_o | output | 1 | Monitor lock select (high-channel word) |
| hi_mon_div_o | output | 1 | Monitor divider select (high-channel word) |
| hi_swallow_o | output | HI_SWAL_W | High-channel swallow count |
| hi_main_div_o | output | 11 | High-channel main divider |
| hi_pre_wide_o | output | 1 | High-channel wide prescaler select |
| hi_pwr_dn_o | output | 1 | High-channel power-down |
| lo_ref_div_o | output | 15 | Low-channel reference divider |
| lo_phase_pos_o | output | 1 | Low-channel phase sense |
| lo_pump_hi_o | output | 1 | Low-channel pump current high |
| lo_out_hiz_o | output | 1 | Low-channel output high-impedance |
| lo_mon_lock_o | output | 1 | Monitor lock select (low-channel word) |
| lo_mon_div_o | output | 1 | Monitor divider select (low-channel word) |
| lo_swallow_o | output | LO_SWAL_W | Low-channel swallow count |
| lo_main_div_o | output | 11 | Low-channel main divider |
| lo_pre_wide_o | output | 1 | Low-channel wide prescaler select |
| lo_pwr_dn_o | output | 1 | Low-channel power-down |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This checks that the latency of a load and the alignment of data with the bit-clock edge scale with the chain depth and are not fixed at two. Swallow widths stay at 7 and 4, so the narrower low-channel field and its dropped bits are covered. Pins are held for five system clocks between changes, which is longer than the chain. One case deliberately raises the bit clock and the strobe together to probe the same-cycle ordering.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int WORD_W = 22;
  localparam int ADDR_W = 2;
  localparam int PAY_W  = WORD_W - ADDR_W;
  localparam int REF_W  = 15;
  localparam int MAIN_W = 11;
  localparam int SWAL_MAX = 7;

  // payload coordinates (shift word minus the address bits)
  localparam int P_POL  = REF_W;
  localparam int P_CUR  = REF_W + 1;
  localparam int P_HIZ  = REF_W + 2;
  localparam int P_MLK  = REF_W + 3;
  localparam int P_MDV  = REF_W + 4;
  localparam int P_MAIN = SWAL_MAX;
  localparam int P_PRE  = SWAL_MAX + MAIN_W;
  localparam int P_PDN  = SWAL_MAX + MAIN_W + 1;

  typedef enum logic [1:0] {
    SEL_LO_REF = 2'b00,
    SEL_LO_CNT = 2'b01,
    SEL_HI_REF = 2'b10,
    SEL_HI_CNT = 2'b11
  } target_e;

  typedef struct packed {
    logic             mon_div;
    logic             mon_lock;
    logic             out_hiz;
    logic             pump_hi;
    logic             phase_pos;
    logic [REF_W-1:0] ref_div;
  } ref_cfg_t;

  typedef struct packed {
    logic              pwr_dn;
    logic              pre_wide;
    logic [MAIN_W-1:0] main_div;
  } cnt_cfg_t;

  function automatic ref_cfg_t unpack_ref(input logic [PAY_W-1:0] p);
    ref_cfg_t r;
    r.ref_div   = p[REF_W-1:0];
    r.phase_pos = p[P_POL];
    r.pump_hi   = p[P_CUR];
    r.out_hiz   = p[P_HIZ];
    r.mon_lock  = p[P_MLK];
    r.mon_div   = p[P_MDV];
    return r;
  endfunction

  function automatic cnt_cfg_t unpack_cnt(input logic [PAY_W-1:0] p);
    cnt_cfg_t c;
    c.main_div = p[P_MAIN +: MAIN_W];
    c.pre_wide = p[P_PRE];
    c.pwr_dn   = p[P_PDN];
    return c;
  endfunction

  localparam cnt_cfg_t CNT_RESET = '{pwr_dn: 1'b1, pre_wide: 1'b0, main_div: '0};
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] ch;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch <= '0;
      else        ch <= STAGES'({ch, din[g]});
    end
    assign dout[g] = ch[STAGES-1];
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/cfg_holding.sv
module cfg_holding
  import pll_cfg_pkg::*;
#(
  parameter int SWAL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ref,
  input  logic              load_cnt,
  input  logic [PAY_W-1:0]  payload,
  output ref_cfg_t          ref_q,
  output cnt_cfg_t          cnt_q,
  output logic [SWAL_W-1:0] swal_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_q <= '0;
    else if (load_ref) ref_q <= unpack_ref(payload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_RESET;
      swal_q <= '0;
    end else if (load_cnt) begin
      cnt_q  <= unpack_cnt(payload);
      swal_q <= payload[SWAL_W-1:0];
    end
  end
endmodule

// File: rtl/dual_pll_cfg_loader.sv
module dual_pll_cfg_loader
  import pll_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HI_SWAL_W   = 7,
  parameter int LO_SWAL_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_bit_clk_i,
  input  logic                 ser_bit_dat_i,
  input  logic                 ser_strobe_i,
  output logic [14:0]          hi_ref_div_o,
  output logic                 hi_phase_pos_o,
  output logic                 hi_pump_hi_o,
  output logic                 hi_out_hiz_o,
  output logic                 hi_mon_lock_o,
  output logic                 hi_mon_div_o,
  output logic [HI_SWAL_W-1:0] hi_swallow_o,
  output logic [10:0]          hi_main_div_o,
  output logic                 hi_pre_wide_o,
  output logic                 hi_pwr_dn_o,
  output logic [14:0]          lo_ref_div_o,
  output logic                 lo_phase_pos_o,
  output logic                 lo_pump_hi_o,
  output logic                 lo_out_hiz_o,
  output logic                 lo_mon_lock_o,
  output logic                 lo_mon_div_o,
  output logic [LO_SWAL_W-1:0] lo_swallow_o,
  output logic [10:0]          lo_main_div_o,
  output logic                 lo_pre_wide_o,
  output logic                 lo_pwr_dn_o
);
  localparam int NUM_TGT = 1 << ADDR_W;

  // synchronized pin levels: [0] bit clock, [1] data, [2] strobe
  logic [2:0] pin_lvl;
  logic [1:0] last_q;
  logic       bit_rise, bit_lvl, strobe_rise;
  logic [WORD_W-1:0]  shift_word;
  logic [ADDR_W-1:0]  sel;
  logic [NUM_TGT-1:0] load_vec;

  sync_chain #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({ser_strobe_i, ser_bit_dat_i, ser_bit_clk_i}),
    .dout  (pin_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= {pin_lvl[2], pin_lvl[0]};
  end

  assign bit_rise    = pin_lvl[0] & ~last_q[0];
  assign bit_lvl     = pin_lvl[1];
  assign strobe_rise = pin_lvl[2] & ~last_q[1];

  cfg_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_rise),
    .bit_in   (bit_lvl),
    .word     (shift_word)
  );

  assign sel = shift_word[ADDR_W-1:0];

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_load
    assign load_vec[g] = strobe_rise && (sel == ADDR_W'(g));
  end

  ref_cfg_t hi_ref, lo_ref;
  cnt_cfg_t hi_cnt, lo_cnt;

  cfg_holding #(.SWAL_W(LO_SWAL_W)) u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ref (load_vec[SEL_LO_REF]),
    .load_cnt (load_vec[SEL_LO_CNT]),
    .payload  (shift_word[WORD_W-1:ADDR_W]),
    .ref_q    (lo_ref),
    .cnt_q    (lo_cnt),
    .swal_q   (lo_swallow_o)
  );

  cfg_holding #(.SWAL_W(HI_SWAL_W)) u_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ref (load_vec[SEL_HI_REF]),
    .load_cnt (load_vec[SEL_HI_CNT]),
    .payload  (shift_word[WORD_W-1:ADDR_W]),
    .ref_q    (hi_ref),
    .cnt_q    (hi_cnt),
    .swal_q   (hi_swallow_o)
  );

  assign hi_ref_div_o   = hi_ref.ref_div;
  assign hi_phase_pos_o = hi_ref.phase_pos;
  assign hi_pump_hi_o   = hi_ref.pump_hi;
  assign hi_out_hiz_o   = hi_ref.out_hiz;
  assign hi_mon_lock_o  = hi_ref.mon_lock;
  assign hi_mon_div_o   = hi_ref.mon_div;
  assign hi_main_div_o  = hi_cnt.main_div;
  assign hi_pre_wide_o  = hi_cnt.pre_wide;
  assign hi_pwr_dn_o    = hi_cnt.pwr_dn;

  assign lo_ref_div_o   = lo_ref.ref_div;
  assign lo_phase_pos_o = lo_ref.phase_pos;
  assign lo_pump_hi_o   = lo_ref.pump_hi;
  assign lo_out_hiz_o   = lo_ref.out_hiz;
  assign lo_mon_lock_o  = lo_ref.mon_lock;
  assign lo_mon_div_o   = lo_ref.mon_div;
  assign lo_main_div_o  = lo_cnt.main_div;
  assign lo_pre_wide_o  = lo_cnt.pre_wide;
  assign lo_pwr_dn_o    = lo_cnt.pwr_dn;
endmodule

// File: rtl/pll_cfg_chk.sv
module pll_cfg_chk #(
  parameter int LO_SWAL_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_rise,
  input logic                 bit_lvl,
  input logic [21:0]          shift_word,
  input logic [3:0]           load_vec,
  input logic [14:0]          hi_ref_div,
  input logic [10:0]          hi_main_div,
  input logic [LO_SWAL_W-1:0] lo_swallow,
  input logic                 lo_pwr_dn
);
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rise |=> shift_word == {$past(shift_word[20:0]), $past(bit_lvl)});

  p_no_idle_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_rise |=> $stable(shift_word));

  p_hi_ref_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_vec[2] |=> hi_ref_div == $past(shift_word[16:2]));

  p_hi_main_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_vec[3] |=> hi_main_div == $past(shift_word[19:9]));

  p_lo_pd_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_vec[1] |=> lo_pwr_dn == $past(shift_word[21]));

  p_lo_swal_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_vec[1] |=> lo_swallow == $past(shift_word[2 +: LO_SWAL_W]));

  p_hold_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_vec[2] |=> $stable(hi_ref_div));
endmodule

bind dual_pll_cfg_loader pll_cfg_chk #(.LO_SWAL_W(LO_SWAL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_rise    (bit_rise),
  .bit_lvl     (bit_lvl),
  .shift_word  (shift_word),
  .load_vec    (load_vec),
  .hi_ref_div  (hi_ref_div_o),
  .hi_main_div (hi_main_div_o),
  .lo_swallow  (lo_swallow_o),
  .lo_pwr_dn   (lo_pwr_dn_o)
);

// File: tb/dual_pll_cfg_loader_bench.sv
`timescale 1ns/1ps
module dual_pll_cfg_loader_bench;
  localparam int SYNC = 3;
  localparam int GAP  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdt = 1'b0, sle = 1'b0;
  always #5 clk = ~clk;

  logic [14:0] hi_ref_div, lo_ref_div;
  logic hi_pol, hi_cur, hi_hiz, hi_mlk, hi_mdv, hi_pre, hi_pdn;
  logic lo_pol, lo_cur, lo_hiz, lo_mlk, lo_mdv, lo_pre, lo_pdn;
  logic [6:0] hi_swal;
  logic [3:0] lo_swal;
  logic [10:0] hi_main, lo_main;

  dual_pll_cfg_loader #(.SYNC_STAGES(SYNC), .HI_SWAL_W(7), .LO_SWAL_W(4)) u_dual_pll_cfg_loader (
    .clk(clk), .rst_n(rst_n),
    .ser_bit_clk_i(sck), .ser_bit_dat_i(sdt), .ser_strobe_i(sle),
    .hi_ref_div_o(hi_ref_div), .hi_phase_pos_o(hi_pol), .hi_pump_hi_o(hi_cur),
    .hi_out_hiz_o(hi_hiz), .hi_mon_lock_o(hi_mlk), .hi_mon_div_o(hi_mdv),
    .hi_swallow_o(hi_swal), .hi_main_div_o(hi_main), .hi_pre_wide_o(hi_pre),
    .hi_pwr_dn_o(hi_pdn),
    .lo_ref_div_o(lo_ref_div), .lo_phase_pos_o(lo_pol), .lo_pump_hi_o(lo_cur),
    .lo_out_hiz_o(lo_hiz), .lo_mon_lock_o(lo_mlk), .lo_mon_div_o(lo_mdv),
    .lo_swallow_o(lo_swal), .lo_main_div_o(lo_main), .lo_pre_wide_o(lo_pre),
    .lo_pwr_dn_o(lo_pdn)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: pin history queues and four stored words
  logic [21:0] m_sh;
  logic [21:0] m_reg [4];
  bit hq_c[$], hq_d[$], hq_l[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = '0;
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      m_reg[1][21] = 1'b1;
      m_reg[3][21] = 1'b1;
      hq_c.delete(); hq_d.delete(); hq_l.delete();
      for (int i = 0; i <= SYNC; i++) begin
        hq_c.push_back(1'b0); hq_d.push_back(1'b0); hq_l.push_back(1'b0);
      end
    end else begin
      int n;
      n = hq_c.size();
      if (hq_l[n-SYNC] && !hq_l[n-SYNC-1]) m_reg[m_sh[1:0]] = m_sh;
      if (hq_c[n-SYNC] && !hq_c[n-SYNC-1]) m_sh = {m_sh[20:0], hq_d[n-SYNC]};
      hq_c.push_back(sck); hq_d.push_back(sdt); hq_l.push_back(sle);
      void'(hq_c.pop_front()); void'(hq_d.pop_front()); void'(hq_l.pop_front());
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R4 hi ref", {hi_mdv, hi_mlk, hi_hiz, hi_cur, hi_pol, hi_ref_div}, m_reg[2][21:2]);
      chk("R4 lo ref", {lo_mdv, lo_mlk, lo_hiz, lo_cur, lo_pol, lo_ref_div}, m_reg[0][21:2]);
      chk("R5 hi cnt", {hi_pdn, hi_pre, hi_main, hi_swal}, m_reg[3][21:2]);
      chk("R5 lo cnt", {lo_pdn, lo_pre, lo_main}, m_reg[1][21:9]);
      chk("R6 lo swallow", lo_swal, m_reg[1][5:2]);
    end
  end

  function automatic logic [21:0] mk_ref(input int r, input bit pol, cur, hiz, ml, md, hi);
    return {md, ml, hiz, cur, pol, 15'(r), hi, 1'b0};
  endfunction
  function automatic logic [21:0] mk_cnt(input int a, input int b, input bit pre, pd, hi);
    return {pd, pre, 11'(b), 7'(a), hi, 1'b1};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic send_bit(input bit b);
    @(negedge clk); sdt = b; wait_n(GAP);
    sck = 1'b1; wait_n(GAP);
    sck = 1'b0; wait_n(GAP);
  endtask
  task automatic send_word(input logic [21:0] w);
    for (int i = 21; i >= 0; i--) send_bit(w[i]);
  endtask
  task automatic strobe();
    @(negedge clk); sle = 1'b1; wait_n(GAP);
    sle = 1'b0; wait_n(GAP);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hi ref", hi_ref_div, 0);
    chk("R1 lo main", lo_main, 0);
    chk("R1 hi pwr_dn", hi_pdn, 1);
    chk("R1 lo pwr_dn", lo_pdn, 1);
    cmp_on = 1'b1;

    // R10 latency, R3/R4 high reference
    send_word(mk_ref(32767, 1, 0, 1, 0, 1, 1));
    @(negedge clk); sle = 1'b1;
    wait_n(SYNC);
    chk("R10 before load", hi_ref_div, 0);
    @(negedge clk);
    chk("R10 at load", hi_ref_div, 15'h7fff);
    chk("R4 hi hiz", hi_hiz, 1);
    wait_n(GAP); sle = 1'b0; wait_n(GAP);

    // R9 low reference loaded while powered down
    send_word(mk_ref(3, 0, 1, 0, 1, 0, 0));
    strobe();
    chk("R9 lo ref while down", lo_ref_div, 3);
    chk("R9 lo still down", lo_pdn, 1);

    // R5 high counter; R7 others untouched
    send_word(mk_cnt(127, 2047, 1, 0, 1));
    strobe();
    chk("R5 hi swallow", hi_swal, 127);
    chk("R5 hi main", hi_main, 2047);
    chk("R7 lo ref kept", lo_ref_div, 3);
    chk("R7 hi ref kept", hi_ref_div, 15'h7fff);

    // R6 low counter, surplus swallow bits dropped
    send_word(mk_cnt(127, 3, 0, 0, 0));
    strobe();
    chk("R6 lo swallow", lo_swal, 15);
    chk("R6 lo main", lo_main, 3);
    chk("R5 lo pwr_dn", lo_pdn, 0);

    // R2 over-long stream keeps the last 22 bits
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_word(mk_ref(1234, 0, 0, 0, 0, 0, 1));
    strobe();
    chk("R2 last bits kept", hi_ref_div, 1234);

    // R8 data wiggles without bit clock, re-strobe reloads same word
    for (int i = 0; i < 6; i++) begin @(negedge clk); sdt = ~sdt; wait_n(2); end
    strobe();
    chk("R8 reload same", hi_ref_div, 1234);
    // R8 bit clock held high across a load, then falls
    send_word(mk_ref(555, 0, 0, 0, 0, 0, 0));
    @(negedge clk); sck = 1'b1; sdt = 1'b0; wait_n(GAP);
    strobe();
    @(negedge clk); sck = 1'b0; wait_n(GAP);
    strobe();
    chk("R8 high clock hold", lo_ref_div, 555 * 2 % 32768);

    // R10 coincident shift and load: pre-shift word is loaded
    send_word(mk_ref(100, 1, 1, 1, 1, 1, 1));
    @(negedge clk); sck = 1'b1; sle = 1'b1; sdt = 1'b1; wait_n(GAP);
    sck = 1'b0; sle = 1'b0; wait_n(GAP);
    chk("R10 coincident load", hi_ref_div, 100);
    chk("R3 coincident target", lo_ref_div, 555 * 2 % 32768);

    wait_n(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule